// File: doc/BRIEF.md
# Buffered Serial Transmitter with Flag Interrupts

This block is the transmit half of an asynchronous serial port. Software talks to it through four byte-wide registers: a data register, a status register and two control registers. A write to the data register fills a one-byte holding buffer. When the shift register is free and the transmitter is enabled, the buffer is copied into it on the next bit tick. The line then carries a low start bit, 5 to 9 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. An external baud generator supplies `bit_tick`, and each bit on the line lasts exactly one tick period.

Because of the holding buffer, software can queue the next byte while the current one is still being sent. Two flags report progress. The empty flag means the buffer can take a new byte. The done flag sets only when the shifter finishes a frame and finds the buffer empty. Three level interrupt lines each follow the logical AND of a flag and its enable bit. The receive-done line is present for register compatibility, but its flag is always zero.

Register map (`reg_addr`): 0 is data (write-only, reads as 0), 1 is status, 2 is control B and 3 is frame format. Control B and frame format read back what was last written.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd` is 1, the status register reads 0x20 (empty flag at bit 5 set, done flag at bit 6 clear, all other bits 0), and all three interrupt lines are 0.
- R2: The line idles high. A frame starts with one low start bit, followed by the data bits with the least significant bit first, and ends with high stop bits. Each bit lasts one `bit_tick` period, and `txd` changes only in the cycle after a tick.
- R3: If control B bit 2 is set, the frame has 9 data bits, and the ninth bit is taken from control B bit 0 at the moment of loading. Otherwise, format bits [2:1] select 5, 6, 7 or 8 data bits for the codes 00, 01, 10 and 11.
- R4: If format bits [5:4] are not 00, a parity bit follows the data bits. Parity is odd when format bit 4 is 1 and even when it is 0.
- R5: If format bit 3 is 1, the frame has two stop bits; otherwise it has one.
- R6: A data write clears the empty flag. Loading the shifter sets the empty flag and clears the done flag.
- R7: If the buffer is full when the last stop bit ends, the next start bit follows on that same tick with no idle bit between frames, and the done flag stays clear.
- R8: The done flag sets when the last stop bit ends and the buffer is empty. It is cleared by writing 1 to status bit 6 or by a `tx_ack` pulse.
- R9: `irq_empty` equals empty flag AND control B bit 5. `irq_tx_done` equals done flag AND control B bit 6. `irq_rx_done` stays 0 because its flag is always clear.
- R10: The buffer is not loaded while control B bit 3 (transmit enable) is 0. Clearing the enable bit during a frame lets that frame finish.
- R11: In a status write, every bit except bit 6 is ignored. In particular, the empty flag cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| bit_tick | input | 1 | One-cycle strobe, one per bit period |
| tx_ack | input | 1 | Acknowledge of the transmit-done interrupt; clears the done flag |
| txd | output | 1 | Serial output line |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_rx_done | output | 1 | Receive-done interrupt request (always low) |
| irq_tx_done | output | 1 | Transmit-done interrupt request |

## Verification
The bench uses the default parameters: 8-bit registers and a 9-bit frame, so every frame length from 5 to 9 can be reached. The bench produces a tick every four clocks. At that rate register writes sometimes land on the same cycle as a load or an end of frame, which tests the priority between software writes and shifter events. The bench also covers a byte queued while another is being sent, a transmitter disabled in the middle of a frame, and each combination of parity and stop bits.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int FRAME_W = 9;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FMT    = 2'd3;

    // status bits
    localparam int ST_EMPTY = 5;
    localparam int ST_DONE  = 6;
    localparam int ST_RXOK  = 7;
    // control B bits
    localparam int CB_BIT8    = 0;
    localparam int CB_WIDE    = 2;
    localparam int CB_TXEN    = 3;
    localparam int CB_IE_EMPT = 5;
    localparam int CB_IE_DONE = 6;
    localparam int CB_IE_RX   = 7;
    // format bits
    localparam int FM_SIZE_LO = 1;
    localparam int FM_SIZE_HI = 2;
    localparam int FM_STOP2   = 3;
    localparam int FM_PAR_ODD = 4;
    localparam int FM_PAR_HI  = 5;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   last;
        logic               par_bit;
        logic               par_en;
        logic               two_stop;
        logic               txd;
    } shift_s;

    typedef struct packed {
        logic [REG_W-1:0] buf_data;
        logic [REG_W-1:0] ctrl_b;
        logic [REG_W-1:0] fmt;
        logic             empty;
        logic             done;
    } regs_s;
endpackage

// File: rtl/serial_tx_format.sv
module serial_tx_format
    import serial_tx_pkg::*;
(
    input  logic [REG_W-1:0]   ctrl_b,
    input  logic [REG_W-1:0]   fmt,
    input  logic [REG_W-1:0]   buf_data,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   last_idx,
    output logic               par_bit,
    output logic               par_en,
    output logic               two_stop
);
    logic [CNT_W-1:0]   nbits;
    logic [FRAME_W-1:0] masked;

    always_comb begin
        frame = {ctrl_b[CB_BIT8], buf_data};
        if (ctrl_b[CB_WIDE]) begin
            nbits = CNT_W'(FRAME_W);
        end else begin
            nbits = CNT_W'(fmt[FM_SIZE_HI:FM_SIZE_LO]) + CNT_W'(5);
        end
        last_idx = nbits - CNT_W'(1);
        for (int i = 0; i < FRAME_W; i++) begin
            masked[i] = frame[i] & (i < int'(nbits));
        end
        par_en   = fmt[FM_PAR_HI] | fmt[FM_PAR_ODD];
        par_bit  = (^masked) ^ fmt[FM_PAR_ODD];
        two_stop = fmt[FM_STOP2];
    end
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
    import serial_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               buf_full,
    input  logic               tx_en,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   last_idx,
    input  logic               par_bit,
    input  logic               par_en,
    input  logic               two_stop,
    output logic               load_pulse,
    output logic               done_pulse,
    output logic               txd
);
    shift_s q, d;
    logic   can_load;

    always_comb begin
        d          = q;
        load_pulse = 1'b0;
        done_pulse = 1'b0;
        can_load   = buf_full & tx_en;
        if (bit_tick) begin
            unique case (q.st)
                TX_IDLE:   if (can_load) load_pulse = 1'b1;
                TX_START:  begin d.st = TX_DATA; d.cnt = '0; end
                TX_DATA: begin
                    if (q.cnt == q.last) begin
                        d.st = q.par_en ? TX_PARITY : TX_STOP1;
                    end else begin
                        d.cnt   = q.cnt + CNT_W'(1);
                        d.shreg = q.shreg >> 1;
                    end
                end
                TX_PARITY: d.st = TX_STOP1;
                TX_STOP1: begin
                    if (q.two_stop)    d.st = TX_STOP2;
                    else if (can_load) load_pulse = 1'b1;
                    else begin d.st = TX_IDLE; done_pulse = 1'b1; end
                end
                TX_STOP2: begin
                    if (can_load) load_pulse = 1'b1;
                    else begin d.st = TX_IDLE; done_pulse = 1'b1; end
                end
                default:   d.st = TX_IDLE;
            endcase
        end
        if (load_pulse) begin
            d.st       = TX_START;
            d.shreg    = frame;
            d.last     = last_idx;
            d.par_bit  = par_bit;
            d.par_en   = par_en;
            d.two_stop = two_stop;
        end
        unique case (d.st)
            TX_START:  d.txd = 1'b0;
            TX_DATA:   d.txd = d.shreg[0];
            TX_PARITY: d.txd = d.par_bit;
            default:   d.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= TX_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd = q.txd;

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE) |-> txd);
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !txd);
    p_no_load_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE && !tx_en) |=> (q.st == TX_IDLE) || $past(load_pulse));
endmodule

// File: rtl/serial_tx_regs.sv
module serial_tx_regs
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              tx_ack,
    input  logic              load_pulse,
    input  logic              done_pulse,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [REG_W-1:0]  ctrl_b,
    output logic [REG_W-1:0]  fmt,
    output logic [REG_W-1:0]  buf_data,
    output logic              buf_full,
    output logic              irq_empty,
    output logic              irq_rx_done,
    output logic              irq_tx_done
);
    regs_s q, d;
    logic  wr_data, wr_stat, wr_ctrl, wr_fmt;
    logic  rx_flag;

    always_comb begin
        wr_data = reg_wr && (reg_addr == ADDR_DATA);
        wr_stat = reg_wr && (reg_addr == ADDR_STATUS);
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_fmt  = reg_wr && (reg_addr == ADDR_FMT);
        d = q;
        if (load_pulse) d.empty = 1'b1;
        if (wr_data) begin
            d.buf_data = reg_wdata;
            d.empty    = 1'b0;
        end
        if (wr_stat && reg_wdata[ST_DONE]) d.done = 1'b0;
        if (tx_ack)                         d.done = 1'b0;
        if (load_pulse)                     d.done = 1'b0;
        if (done_pulse)                     d.done = 1'b1;
        if (wr_ctrl) d.ctrl_b = reg_wdata;
        if (wr_fmt)  d.fmt    = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_flag = 1'b0;

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: begin
                reg_rdata           = '0;
                reg_rdata[ST_EMPTY] = q.empty;
                reg_rdata[ST_DONE]  = q.done;
                reg_rdata[ST_RXOK]  = rx_flag;
            end
            ADDR_CTRL: reg_rdata = q.ctrl_b;
            ADDR_FMT:  reg_rdata = q.fmt;
            default:   reg_rdata = '0;
        endcase
    end

    assign ctrl_b      = q.ctrl_b;
    assign fmt         = q.fmt;
    assign buf_data    = q.buf_data;
    assign buf_full    = ~q.empty;
    assign irq_empty   = q.empty & q.ctrl_b[CB_IE_EMPT];
    assign irq_tx_done = q.done  & q.ctrl_b[CB_IE_DONE];
    assign irq_rx_done = rx_flag & q.ctrl_b[CB_IE_RX];

    p_write_clears_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !buf_full == 1'b0);
    p_load_sets_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !wr_data) |=> !buf_full);
    p_done_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> reg_wdata == reg_wdata && q.done);
    p_ack_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack && !done_pulse) |=> !irq_tx_done);
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bit_tick,
    input  logic              tx_ack,
    output logic              txd,
    output logic              irq_empty,
    output logic              irq_rx_done,
    output logic              irq_tx_done
);
    logic [REG_W-1:0]   ctrl_b, fmt, buf_data;
    logic               buf_full, load_pulse, done_pulse;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   last_idx;
    logic               par_bit, par_en, two_stop;

    serial_tx_regs i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_ack(tx_ack), .load_pulse(load_pulse),
        .done_pulse(done_pulse), .reg_rdata(reg_rdata), .ctrl_b(ctrl_b),
        .fmt(fmt), .buf_data(buf_data), .buf_full(buf_full),
        .irq_empty(irq_empty), .irq_rx_done(irq_rx_done), .irq_tx_done(irq_tx_done)
    );

    serial_tx_format i_format (
        .ctrl_b(ctrl_b), .fmt(fmt), .buf_data(buf_data), .frame(frame),
        .last_idx(last_idx), .par_bit(par_bit), .par_en(par_en), .two_stop(two_stop)
    );

    serial_tx_shifter i_shifter (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .buf_full(buf_full),
        .tx_en(ctrl_b[CB_TXEN]), .frame(frame), .last_idx(last_idx),
        .par_bit(par_bit), .par_en(par_en), .two_stop(two_stop),
        .load_pulse(load_pulse), .done_pulse(done_pulse), .txd(txd)
    );

    p_tx_idle_when_reset_r1: assert property (@(posedge clk)
        !rst_n |=> txd && !irq_rx_done);
    p_rx_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_rx_done);
endmodule

// File: tb/test_serial_tx_core.sv
module test_serial_tx_core;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd1;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bit_tick = 1'b0;
    logic       tx_ack = 1'b0;
    logic       txd, irq_empty, irq_rx_done, irq_tx_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    serial_tx_core i_serial_tx_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
        .tx_ack(tx_ack), .txd(txd), .irq_empty(irq_empty),
        .irq_rx_done(irq_rx_done), .irq_tx_done(irq_tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // tick generator, driven a quarter period after the rising edge
    int tcnt = 0;
    always @(posedge clk) begin
        #(QTR);
        if (tcnt == TICK_DIV - 1) begin tcnt = 0; bit_tick = 1'b1; end
        else begin tcnt++; bit_tick = 1'b0; end
    end

    // behavioural reference model
    int         m_bits[$];
    bit         m_empty, m_done;
    logic [7:0] m_buf, m_cb, m_fm;

    function automatic void build_frame();
        int   nb;
        bit   p;
        logic [8:0] f;
        nb = m_cb[2] ? 9 : (int'(m_fm[2:1]) + 5);
        f  = {m_cb[0], m_buf};
        p  = 1'b0;
        m_bits.delete();
        m_bits.push_back(0);
        for (int i = 0; i < nb; i++) begin
            m_bits.push_back(int'(f[i]));
            p ^= f[i];
        end
        if (m_fm[5:4] != 2'b00) m_bits.push_back(int'(p ^ m_fm[4]));
        m_bits.push_back(1);
        if (m_fm[3]) m_bits.push_back(1);
    endfunction

    always @(posedge clk) begin
        bit can, ld, dn;
        if (!rst_n) begin
            m_bits.delete();
            m_empty = 1'b1; m_done = 1'b0;
            m_buf = '0; m_cb = '0; m_fm = '0;
        end else begin
            can = !m_empty && m_cb[3];
            ld = 1'b0; dn = 1'b0;
            if (bit_tick) begin
                if (m_bits.size() > 1) begin
                    void'(m_bits.pop_front());
                end else if (m_bits.size() == 1) begin
                    void'(m_bits.pop_front());
                    if (can) ld = 1'b1; else dn = 1'b1;
                end else if (can) begin
                    ld = 1'b1;
                end
            end
            if (ld) begin build_frame(); m_empty = 1'b1; end
            if (reg_wr && reg_addr == 2'd1 && reg_wdata[6]) m_done = 1'b0;
            if (tx_ack) m_done = 1'b0;
            if (ld) m_done = 1'b0;
            if (dn) m_done = 1'b1;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: begin m_buf = reg_wdata; m_empty = 1'b0; end
                    2'd2: m_cb = reg_wdata;
                    2'd3: m_fm = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 txd line (R3 R4 R5 R7 framing)", int'(txd),
                (m_bits.size() > 0) ? m_bits[0] : 1);
            chk("R9 irq_empty", int'(irq_empty), int'(m_empty & m_cb[5]));
            chk("R9 irq_tx_done", int'(irq_tx_done), int'(m_done & m_cb[6]));
            chk("R9 irq_rx_done", int'(irq_rx_done), 0);
            if (reg_addr == 2'd1 && !reg_wr)
                chk("R6 status", int'(reg_rdata), int'({1'b0, m_done, m_empty, 5'b0}));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(posedge clk); #(QTR);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #(QTR);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_status(input string tag, input int exp);
        @(negedge clk);
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (reg_rdata[5]) break;
        end
    endtask

    task automatic send(input logic [7:0] cb, input logic [7:0] fm, input logic [7:0] v);
        wr(2'd3, fm);
        wr(2'd2, cb);
        wr(2'd0, v);
        wait_cyc(80);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        #(QTR);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 status after reset", int'(reg_rdata), 8'h20);
        chk("R1 txd after reset", int'(txd), 1);
        chk("R1 irqs after reset", int'({irq_empty, irq_rx_done, irq_tx_done}), 0);

        // R10 disabled: buffered byte is held
        wr(2'd3, 8'h06);
        wr(2'd0, 8'hA5);
        expect_status("R6 write clears empty", 8'h00);
        wait_cyc(60);
        expect_status("R10 no load while disabled", 8'h00);
        chk("R10 line idle while disabled", int'(txd), 1);

        // enable: frame sent, done flag sets
        wr(2'd2, 8'h08);
        wait_cyc(80);
        expect_status("R8 done after drain", 8'h60);
        @(posedge clk); #(QTR); tx_ack = 1'b1;
        @(posedge clk); #(QTR); tx_ack = 1'b0;
        expect_status("R8 ack clears done", 8'h20);

        // R9 interrupts and R7 back-to-back
        wr(2'd2, 8'h68);
        @(negedge clk);
        chk("R9 irq_empty follows flag", int'(irq_empty), 1);
        chk("R9 irq_tx_done low", int'(irq_tx_done), 0);
        wr(2'd0, 8'h3C);
        wait_empty();
        wr(2'd0, 8'hC3);
        wait_cyc(110);
        expect_status("R7 done only after second frame", 8'h60);
        chk("R9 irq_tx_done high", int'(irq_tx_done), 1);
        wr(2'd1, 8'hBF);
        expect_status("R11 status write without bit 6 ignored", 8'h60);
        wr(2'd1, 8'h40);
        expect_status("R8 write one clears done", 8'h20);
        chk("R9 irq_tx_done cleared", int'(irq_tx_done), 0);

        // R3 R4 R5 formats
        send(8'h08, 8'h28, 8'h1B);   // 5 bits, even parity, two stops
        send(8'h08, 8'h12, 8'h2D);   // 6 bits, odd parity
        send(8'h08, 8'h34, 8'h55);   // 7 bits, mode 11 odd
        send(8'h08, 8'h26, 8'h96);   // 8 bits, even parity
        send(8'h0D, 8'h06, 8'h55);   // 9 bits, ninth = 1
        send(8'h0C, 8'h1E, 8'hF0);   // 9 bits, ninth = 0, odd, two stops

        // R10 disable during a frame: frame completes, next byte held
        wr(2'd1, 8'h40);
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h81);
        wait_cyc(14);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h7E);
        wait_cyc(100);
        expect_status("R10 frame finished, buffer held", 8'h40);
        chk("R10 line idle after finish", int'(txd), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule